// File: doc/BRIEF.md
# Per-Trigger Prescaler with Rate Scalers

This block sits at the single central point that sees the processor decision for every event. Each event arrives as a strobe with a vector of per-trigger pass bits. For each trigger the block applies one of two thinning rules, chosen per trigger. The count rule keeps one pass out of every N. The rate rule keeps at most one pass per configured number of clock cycles, using a timer for each trigger. The block then returns the thinned trigger vector and an overall accept one cycle after the strobe.

The same block keeps the monitoring counts: events entering, events for which the algorithm passed at least one trigger, and events still accepted after thinning. It also counts passes and keeps for each trigger. All counters saturate. They are read through a combinational register read port. Prescale values and modes are set by register writes. A clear strobe zeroes every counter and timer and leaves the configuration in place.

Top module: `trig_prescaler`

## Requirements
- R1: After reset, acc_valid, acc_bits and acc_any are low, every counter reads zero, and every trigger is in count mode with value 1, so passes go through unchanged.
- R2: acc_valid is high in exactly the cycle after a clock edge at which dec_valid is high and clr is low, and is low in every other cycle. acc_bits and acc_any belong to that event.
- R3: In count mode (cfg_rate=0) with value N≥1, a trigger is kept on the Nth, 2Nth and later multiples of N of its passes, counted since the last reset, clear or write to that trigger. N=1 keeps every pass. A kept bit is never set unless the matching dec_bits bit was set.
- R4: In rate mode (cfg_rate=1) with value T≥1, a pass is kept only if at least T cycles have gone by since that trigger's last keep. The first pass after a reset, clear or write to the trigger is kept. T=1 keeps every pass.
- R5: A value of 0 disables the trigger in either mode: its acc_bits bit is never set.
- R6: acc_any is the OR of acc_bits.
- R7: Read address 0 returns the number of events, address 1 the number of events with any dec_bits bit set, and address 2 the number of events with any acc_bits bit set.
- R8: Read address NTRIG+i returns the number of passes of trigger i, and address 2*NTRIG+i the number of keeps of trigger i.
- R9: Every counter saturates at all ones and does not wrap.
- R10: clr zeroes all counters, prescale counters and timers and leaves values and modes unchanged. A decision strobe in the same cycle is dropped: no acc_valid, and nothing is counted.
- R11: A write (cfg_we with cfg_sel, cfg_rate, cfg_val) sets that trigger's mode and value and restarts its counter or timer. It applies from the next event.
- R12: rd_data follows rd_addr combinationally, and any unmapped address (3 to NTRIG-1, or 3*NTRIG and above) returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Clear all counters and timers |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | $clog2(NTRIG) | Trigger index to write |
| cfg_rate | input | 1 | 1 = rate mode, 0 = count mode |
| cfg_val | input | PW | Prescale count or interval in cycles |
| dec_valid | input | 1 | Decision strobe |
| dec_bits | input | NTRIG | Per-trigger pass bits |
| acc_valid | output | 1 | Accept result valid |
| acc_bits | output | NTRIG | Per-trigger bits after thinning |
| acc_any | output | 1 | Overall accept |
| rd_addr | input | $clog2(3*NTRIG) | Counter read address |
| rd_data | output | CW | Counter read data |

## Verification
The assertions expect reset to be held low for at least one clock edge before any strobe. They also assume that a write to a trigger may coincide with a decision, in which case the decision uses the old setting. The rate-mode spacing assertion only applies when no write to that trigger happened at the edge of the keep. The bench never writes during a decision, and it changes inputs only on falling edges. Strobes are sent either back to back, which exercises the timers at one event per cycle, or with one idle cycle between them, which is what the interval test relies on.

// File: rtl/trig_prescaler.sv
module trig_prescaler #(
  parameter int NTRIG = 8,
  parameter int PW    = 16,
  parameter int CW    = 32,
  localparam int IW   = $clog2(NTRIG),
  localparam int AW   = $clog2(3*NTRIG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cfg_we,
  input  logic [IW-1:0]    cfg_sel,
  input  logic             cfg_rate,
  input  logic [PW-1:0]    cfg_val,
  input  logic             dec_valid,
  input  logic [NTRIG-1:0] dec_bits,
  output logic             acc_valid,
  output logic [NTRIG-1:0] acc_bits,
  output logic             acc_any,
  input  logic [AW-1:0]    rd_addr,
  output logic [CW-1:0]    rd_data
);

  logic [PW-1:0]    pv_q   [NTRIG];
  logic [NTRIG-1:0] rate_q;
  logic [PW-1:0]    st_q   [NTRIG];
  logic [PW-1:0]    st_nxt [NTRIG];
  logic [CW-1:0]    pass_cnt [NTRIG];
  logic [CW-1:0]    kept_cnt [NTRIG];
  logic [CW-1:0]    in_cnt, alg_cnt, out_cnt;
  logic [NTRIG-1:0] keep, armed, hit, seen;

  wire ev = dec_valid & ~clr;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v == '1) ? v : v + CW'(1);
  endfunction

  always_comb begin
    for (int i = 0; i < NTRIG; i++) begin
      armed[i]  = pv_q[i] != '0;
      hit[i]    = rate_q[i] ? (st_q[i] == '0) : (st_q[i] == pv_q[i] - PW'(1));
      seen[i]   = ev & dec_bits[i] & armed[i];
      keep[i]   = seen[i] & hit[i];
      st_nxt[i] = st_q[i];
      if (rate_q[i]) begin
        if (keep[i])             st_nxt[i] = pv_q[i] - PW'(1);
        else if (st_q[i] != '0)  st_nxt[i] = st_q[i] - PW'(1);
      end else if (seen[i]) begin
        st_nxt[i] = hit[i] ? '0 : st_q[i] + PW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      acc_bits  <= '0;
      acc_any   <= 1'b0;
      in_cnt    <= '0;
      alg_cnt   <= '0;
      out_cnt   <= '0;
      rate_q    <= '0;
      for (int i = 0; i < NTRIG; i++) begin
        pv_q[i]     <= PW'(1);
        st_q[i]     <= '0;
        pass_cnt[i] <= '0;
        kept_cnt[i] <= '0;
      end
    end else begin
      acc_valid <= ev;
      acc_bits  <= keep;
      acc_any   <= |keep;
      if (clr) begin
        in_cnt  <= '0;
        alg_cnt <= '0;
        out_cnt <= '0;
      end else if (ev) begin
        in_cnt <= sat_inc(in_cnt);
        if (|dec_bits) alg_cnt <= sat_inc(alg_cnt);
        if (|keep)     out_cnt <= sat_inc(out_cnt);
      end
      for (int i = 0; i < NTRIG; i++) begin
        if (cfg_we && cfg_sel == IW'(i)) begin
          pv_q[i]   <= cfg_val;
          rate_q[i] <= cfg_rate;
        end
        if (clr || (cfg_we && cfg_sel == IW'(i))) st_q[i] <= '0;
        else                                      st_q[i] <= st_nxt[i];
        if (clr) begin
          pass_cnt[i] <= '0;
          kept_cnt[i] <= '0;
        end else begin
          if (ev && dec_bits[i]) pass_cnt[i] <= sat_inc(pass_cnt[i]);
          if (keep[i])           kept_cnt[i] <= sat_inc(kept_cnt[i]);
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(0)) rd_data = in_cnt;
    if (rd_addr == AW'(1)) rd_data = alg_cnt;
    if (rd_addr == AW'(2)) rd_data = out_cnt;
    for (int i = 0; i < NTRIG; i++) begin
      if (rd_addr == AW'(NTRIG + i))   rd_data = pass_cnt[i];
      if (rd_addr == AW'(2*NTRIG + i)) rd_data = kept_cnt[i];
    end
  end

  a_r2_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !clr) |=> acc_valid);
  a_r2_quiet_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_valid && !clr) |=> !acc_valid);
  a_r3_kept_only_if_passed: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !clr) |=> ((acc_bits & ~$past(dec_bits)) == '0));
  a_r6_any_matches_bits: assert property (@(posedge clk) disable iff (!rst_n)
    acc_any == (acc_bits != '0));
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cnt == '1 && !clr) |=> in_cnt == '1);
  a_r10_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (in_cnt == '0 && alg_cnt == '0 && out_cnt == '0 && !acc_valid));

  for (genvar g = 0; g < NTRIG; g++) begin : g_chk
    a_r5_disabled_never_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !clr && pv_q[g] == '0) |=> !acc_bits[g]);
    a_r4_rate_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_bits[g] && rate_q[g] && pv_q[g] > PW'(1)
       && !($past(cfg_we) && $past(cfg_sel) == IW'(g))) |=> !acc_bits[g]);
  end

endmodule

// File: tb/test_trig_prescaler.sv
`timescale 1ns/1ps
module test_trig_prescaler;
  localparam int NTRIG = 8;
  localparam int PW = 16;
  localparam int CW = 8;
  localparam int IW = $clog2(NTRIG);
  localparam int AW = $clog2(3*NTRIG);

  // upper byte: decision bits, lower byte: expected kept bits (back-to-back events)
  localparam logic [15:0] VEC [8] = '{16'hFF71, 16'hFF63, 16'h0F05, 16'hF070,
                                      16'hFF63, 16'h0000, 16'h5551, 16'hAA20};

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, cfg_we = 1'b0, cfg_rate = 1'b0, dec_valid = 1'b0;
  logic [IW-1:0] cfg_sel = '0;
  logic [PW-1:0] cfg_val = '0;
  logic [NTRIG-1:0] dec_bits = '0;
  logic acc_valid, acc_any;
  logic [NTRIG-1:0] acc_bits;
  logic [AW-1:0] rd_addr = '0;
  logic [CW-1:0] rd_data;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  trig_prescaler #(.NTRIG(NTRIG), .PW(PW), .CW(CW)) i_trig_prescaler (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_rate(cfg_rate), .cfg_val(cfg_val), .dec_valid(dec_valid), .dec_bits(dec_bits),
    .acc_valid(acc_valid), .acc_bits(acc_bits), .acc_any(acc_any),
    .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [CW-1:0] v);
    rd_addr = AW'(a);
    #1;
    v = rd_data;
  endtask

  task automatic cfg(input int idx, input logic rate, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = IW'(idx); cfg_rate = rate; cfg_val = PW'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic send(input logic [7:0] bits, input logic [7:0] exp, input string tag);
    @(negedge clk);
    dec_valid = 1'b1; dec_bits = bits;
    @(negedge clk);
    dec_valid = 1'b0;
    chk({tag, " valid"}, {31'd0, acc_valid}, 32'd1);
    chk({tag, " bits"}, {24'd0, acc_bits}, {24'd0, exp});
    chk({tag, " any"}, {31'd0, acc_any}, {31'd0, exp != 8'h00});
  endtask

  initial begin
    #(8 * 5000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 acc_valid", {31'd0, acc_valid}, 0);
    rd(0, v); chk("R1 in count", {24'd0, v}, 0);
    rd(2*NTRIG + 5, v); chk("R1 kept count", {24'd0, v}, 0);
    send(8'hA5, 8'hA5, "R1 default pass-through");

    // R11 configuration
    cfg(0, 1'b0, 1); cfg(1, 1'b0, 2); cfg(2, 1'b0, 3); cfg(3, 1'b0, 0);
    cfg(4, 1'b1, 3); cfg(5, 1'b1, 1); cfg(6, 1'b0, 1); cfg(7, 1'b1, 0);
    pulse_clr();

    // R3 R4 R5 table of back-to-back events
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (k > 0) begin
        chk("R2 table valid", {31'd0, acc_valid}, 1);
        chk("R3/R4/R5 table bits", {24'd0, acc_bits}, {24'd0, VEC[k-1][7:0]});
      end
      dec_valid = 1'b1; dec_bits = VEC[k][15:8];
    end
    @(negedge clk);
    dec_valid = 1'b0;
    chk("R3/R4/R5 table bits last", {24'd0, acc_bits}, {24'd0, VEC[7][7:0]});
    @(negedge clk);
    chk("R2 idle", {31'd0, acc_valid}, 0);

    // R7 R8 counters
    rd(0, v); chk("R7 events in", {24'd0, v}, 8);
    rd(1, v); chk("R7 algorithm pass", {24'd0, v}, 7);
    rd(2, v); chk("R7 events out", {24'd0, v}, 7);
    rd(NTRIG + 4, v); chk("R8 pass t4", {24'd0, v}, 5);
    rd(2*NTRIG + 4, v); chk("R8 kept t4", {24'd0, v}, 3);
    rd(NTRIG + 3, v); chk("R8 pass t3", {24'd0, v}, 5);
    rd(2*NTRIG + 3, v); chk("R5 kept t3 disabled", {24'd0, v}, 0);
    rd(5, v); chk("R12 unmapped low", {24'd0, v}, 0);
    rd(3*NTRIG, v); chk("R12 unmapped high", {24'd0, v}, 0);

    // R10 clear keeps configuration, restarts the prescale counter
    pulse_clr();
    rd(0, v); chk("R10 in cleared", {24'd0, v}, 0);
    rd(2*NTRIG, v); chk("R10 kept cleared", {24'd0, v}, 0);
    send(8'h02, 8'h00, "R10 t1 first after clear");
    send(8'h02, 8'h02, "R10 t1 second after clear");

    // R4 interval with one idle cycle between events, T=3
    pulse_clr();
    send(8'h10, 8'h10, "R4 first kept");
    send(8'h10, 8'h00, "R4 within interval");
    send(8'h10, 8'h10, "R4 after interval");

    // R5 disabled rate trigger, R6 overall accept low
    send(8'h80, 8'h00, "R5 R6 rate value 0");

    // R11 write changes value
    cfg(3, 1'b0, 1);
    send(8'h08, 8'h08, "R11 t3 enabled by write");

    // R10 clear and strobe together
    @(negedge clk);
    clr = 1'b1; dec_valid = 1'b1; dec_bits = 8'hFF;
    @(negedge clk);
    clr = 1'b0; dec_valid = 1'b0;
    chk("R10 strobe dropped", {31'd0, acc_valid}, 0);
    rd(0, v); chk("R10 strobe not counted", {24'd0, v}, 0);

    // R9 saturation
    @(negedge clk);
    dec_valid = 1'b1; dec_bits = 8'h01;
    repeat (260) @(negedge clk);
    dec_valid = 1'b0;
    rd(0, v); chk("R9 in saturates", {24'd0, v}, 255);
    rd(2*NTRIG, v); chk("R9 kept t0 saturates", {24'd0, v}, 255);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule